// File: doc/BRIEF.md
# Floating-Point Compare Flag Generator

This block takes two binary-format floating-point words, a left operand `opd_d` and a right operand `opd_m`, and reports how they relate as four processor condition flags (N, Z, C, V) plus an invalid-operation flag. It does no arithmetic. The ordering comes only from the sign bits and from integer comparison of the raw bit patterns. This gives a cheap compare path for a scalar floating-point unit.

A 2-bit mode selects among four variants. Bit 0 picks signalling behaviour: every NaN raises invalid. When bit 0 is clear, only signalling NaNs raise invalid. Bit 1 picks compare-against-zero, where the right operand is replaced by positive zero. An input is taken when `in_valid` is high, and its result is registered and presented one cycle later with `out_valid`.

Top module: `fcmp_flags`

## Requirements
- R1: `flags_nzcv` holds N in bit 3, Z in bit 2, C in bit 1 and V in bit 0. The four relations are encoded as follows: less-than = 4'b1000, equal = 4'b0110, greater-than = 4'b0010, unordered = 4'b0011.
- R2: A word whose exponent field is all ones and whose fraction is nonzero is a NaN. Either operand being a NaN makes the result unordered.
- R3: `invalid` is set when any operand is a NaN while mode bit 0 is 1. When mode bit 0 is 0, it is set only for a NaN whose fraction MSB is 0. With no NaN, `invalid` is 0.
- R4: The operands compare equal when their bit patterns are identical, or when both are zeros of any sign.
- R5: When the signs differ and the operands are not equal, the operand with the sign bit set is the smaller one.
- R6: When the signs match, the unsigned bit patterns decide the order. The outcome is reversed when both operands are negative, so infinities order beyond every finite value.
- R7: When mode bit 1 is 1, `opd_m` is ignored and +0 takes its place. Mode bit 0 still selects quiet or signalling handling.
- R8: `out_valid` rises exactly one cycle after an accepted input. While `in_valid` is low, `flags_nzcv` and `invalid` keep their last values.
- R9: After reset, `out_valid`, `flags_nzcv` and `invalid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and mode are accepted on this cycle |
| mode | input | 2 | Bit 0: signalling; bit 1: compare against +0 |
| opd_d | input | EXP_W+FRAC_W+1 | Left operand |
| opd_m | input | EXP_W+FRAC_W+1 | Right operand (ignored in zero mode) |
| out_valid | output | 1 | Result registers were loaded on the previous cycle |
| flags_nzcv | output | 4 | Relation as N,Z,C,V |
| invalid | output | 1 | Invalid-operation indication |

## Verification
The main bench instance uses a 3-bit exponent and a 2-bit fraction, which gives 64 distinct words. Every ordered pair is run under all four modes. That covers every sign, zero, subnormal, infinity, quiet NaN and signalling NaN combination. The expected relation comes from converting each word to a real number, so the bench ordering is independent of the bit-pattern trick. A second instance at the default single-precision width gets directed cases to confirm the parameterisation.

// File: rtl/fcmp_pkg.sv
// Shared types for the compare flag generator.
// Assumes the relation encoding below is consumed by condition-code logic.
package fcmp_pkg;
    typedef enum logic [3:0] {
        REL_LT = 4'b1000,
        REL_EQ = 4'b0110,
        REL_GT = 4'b0010,
        REL_UN = 4'b0011
    } rel_flags_e;

    typedef struct packed {
        logic is_nan;
        logic quiet_bit;
        logic mag_zero;
    } opd_class_t;
endpackage

// File: rtl/fcmp_classify.sv
// Classifies one operand word: NaN, quiet bit, zero magnitude.
// Assumes layout {sign, exponent[EXP_W], fraction[FRAC_W]}.
module fcmp_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = EXP_W + FRAC_W + 1
) (
    input  logic [W-1:0]           word,
    output fcmp_pkg::opd_class_t   cls
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign exp_f  = word[W-2 -: EXP_W];
    assign frac_f = word[FRAC_W-1:0];

    // Decode the class bits from the fields.
    always_comb begin
        cls.is_nan    = (&exp_f) && (|frac_f);
        cls.quiet_bit = frac_f[FRAC_W-1];
        cls.mag_zero  = ~|word[W-2:0];
    end
endmodule

// File: rtl/fcmp_order.sv
// Orders two non-NaN words by sign and raw pattern; NaN forces unordered.
// Assumes nan_any comes from the operand classifiers.
module fcmp_order #(
    parameter int W = 32
) (
    input  logic [W-1:0]          d_w,
    input  logic [W-1:0]          m_w,
    input  logic                  nan_any,
    input  logic                  both_zero,
    output fcmp_pkg::rel_flags_e  rel
);
    import fcmp_pkg::*;

    logic sgn_d, sgn_m, mag_lt;

    assign sgn_d  = d_w[W-1];
    assign sgn_m  = m_w[W-1];
    assign mag_lt = d_w < m_w;

    // Select the relation with NaN, equality, sign, then magnitude priority.
    always_comb begin
        if (nan_any)                          rel = REL_UN;
        else if (d_w == m_w || both_zero)     rel = REL_EQ;
        else if (sgn_d != sgn_m)              rel = sgn_d ? REL_LT : REL_GT;
        else if (sgn_d ? !mag_lt : mag_lt)    rel = REL_LT;
        else                                  rel = REL_GT;
    end
endmodule

// File: rtl/fcmp_flags.sv
// Top: compare flag generator with quiet/signalling and zero-compare modes.
// Assumes one compare per accepted input; result registered one cycle later.
module fcmp_flags #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = EXP_W + FRAC_W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [1:0]    mode,
    input  logic [W-1:0]  opd_d,
    input  logic [W-1:0]  opd_m,
    output logic          out_valid,
    output logic [3:0]    flags_nzcv,
    output logic          invalid
);
    import fcmp_pkg::*;

    localparam int NOPD = 2;

    logic                 sig_mode;
    logic [W-1:0]         m_eff;
    logic [W-1:0]         opd_arr [NOPD];
    opd_class_t           cls_arr [NOPD];
    logic [NOPD-1:0]      opd_inv;
    logic                 nan_any;
    rel_flags_e           rel;

    assign sig_mode   = mode[0];
    assign m_eff      = mode[1] ? '0 : opd_m;
    assign opd_arr[0] = opd_d;
    assign opd_arr[1] = m_eff;

    genvar gi;
    generate
        for (gi = 0; gi < NOPD; gi++) begin : g_opd
            fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
                .word (opd_arr[gi]),
                .cls  (cls_arr[gi])
            );
            assign opd_inv[gi] = cls_arr[gi].is_nan &&
                                 (sig_mode || !cls_arr[gi].quiet_bit);
        end
    endgenerate

    assign nan_any = cls_arr[0].is_nan || cls_arr[1].is_nan;

    fcmp_order #(.W(W)) u_ord (
        .d_w       (opd_d),
        .m_w       (m_eff),
        .nan_any   (nan_any),
        .both_zero (cls_arr[0].mag_zero && cls_arr[1].mag_zero),
        .rel       (rel)
    );

    // Register the result on accepted input, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            flags_nzcv <= 4'b0000;
            invalid    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                flags_nzcv <= rel;
                invalid    <= |opd_inv;
            end
        end
    end
endmodule

// File: rtl/fcmp_flags_chk.sv
// Checker for fcmp_flags, attached by bind; observes ports only.
module fcmp_flags_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = EXP_W + FRAC_W + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [1:0]    mode,
    input logic [W-1:0]  opd_d,
    input logic [W-1:0]  opd_m,
    input logic          out_valid,
    input logic [3:0]    flags_nzcv,
    input logic          invalid
);
    logic d_nan;
    assign d_nan = (&opd_d[W-2 -: EXP_W]) && (|opd_d[FRAC_W-1:0]);

    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flags_nzcv == 4'b1000 || flags_nzcv == 4'b0110 ||
                       flags_nzcv == 4'b0010 || flags_nzcv == 4'b0011)); // R1
    AST_D_NAN_UNORD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && d_nan) |=> (flags_nzcv == 4'b0011)); // R2
    AST_INV_NEEDS_UNORD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && invalid) |-> flags_nzcv[0]); // R3
    AST_ZERO_SELF_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode[1] && opd_d == '0) |=> (flags_nzcv == 4'b0110)); // R7
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(flags_nzcv) && $stable(invalid) && !out_valid)); // R8
endmodule

bind fcmp_flags fcmp_flags_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .opd_d(opd_d), .opd_m(opd_m), .out_valid(out_valid),
    .flags_nzcv(flags_nzcv), .invalid(invalid)
);

// File: tb/tb_fcmp_flags.sv
`timescale 1ns/1ps
module tb_fcmp_flags;
    localparam int EW = 3;
    localparam int FW = 2;
    localparam int W  = EW + FW + 1;
    localparam int BIAS = (1 << (EW - 1)) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [W-1:0] opd_d = '0, opd_m = '0;
    logic out_valid, invalid;
    logic [3:0] flags_nzcv;

    logic in_valid32 = 1'b0;
    logic [1:0] mode32 = 2'b00;
    logic [31:0] d32 = '0, m32 = '0;
    logic ov32, inv32;
    logic [3:0] fl32;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fcmp_flags #(.EXP_W(EW), .FRAC_W(FW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .opd_d(opd_d), .opd_m(opd_m), .out_valid(out_valid),
        .flags_nzcv(flags_nzcv), .invalid(invalid));

    fcmp_flags dut32 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid32), .mode(mode32),
        .opd_d(d32), .opd_m(m32), .out_valid(ov32),
        .flags_nzcv(fl32), .invalid(inv32));

    function automatic real pow2(input int k);
        real r = 1.0;
        if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
        else        for (int i = 0; i < -k; i++) r = r / 2.0;
        return r;
    endfunction

    function automatic bit is_nan(input logic [W-1:0] x);
        return (&x[W-2 -: EW]) && (|x[FW-1:0]);
    endfunction

    function automatic real value(input logic [W-1:0] x);
        int e = int'(x[W-2 -: EW]);
        int f = int'(x[FW-1:0]);
        real mag;
        if (e == (1 << EW) - 1) mag = 1.0e9;
        else if (e == 0)        mag = f * pow2(1 - BIAS - FW);
        else                    mag = ((1 << FW) + f) * pow2(e - BIAS - FW);
        return x[W-1] ? -mag : mag;
    endfunction

    // Reference model from the requirements.
    task automatic model(input logic [W-1:0] d, input logic [W-1:0] m_in,
                         input logic [1:0] md, output logic [3:0] f, output logic inv);
        logic [W-1:0] m = md[1] ? '0 : m_in;
        real vd, vm;
        inv = 1'b0;
        if (is_nan(d) && (md[0] || !d[FW-1])) inv = 1'b1;           // R3
        if (is_nan(m) && (md[0] || !m[FW-1])) inv = 1'b1;           // R3
        if (is_nan(d) || is_nan(m)) f = 4'b0011;                    // R2
        else begin
            vd = value(d); vm = value(m);
            if (vd == vm)     f = 4'b0110;                          // R4
            else if (vd < vm) f = 4'b1000;                          // R5 R6
            else              f = 4'b0010;
        end
    endtask

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3:0] ef;
        logic ei;
        logic [3:0] held_f;
        logic held_i;
        repeat (3) @(negedge clk);
        check("R9 reset", {out_valid, flags_nzcv, invalid}, 6'b0);
        check("R9 reset32", {ov32, fl32, inv32}, 6'b0);
        rst_n = 1'b1;
        // Exhaustive sweep: R1..R7
        for (int md = 0; md < 4; md++) begin
            for (int a = 0; a < (1 << W); a++) begin
                for (int b = 0; b < (1 << W); b++) begin
                    in_valid = 1'b1; mode = md[1:0];
                    opd_d = a[W-1:0]; opd_m = b[W-1:0];
                    model(opd_d, opd_m, mode, ef, ei);
                    @(negedge clk);
                    check(md[1] ? "R7 zero-mode" : "R1 R2 R3 R4 R5 R6 sweep",
                          {out_valid, flags_nzcv, invalid}, {1'b1, ef, ei});
                end
            end
        end
        // R8: hold while idle, opd_m changed
        held_f = flags_nzcv; held_i = invalid;
        in_valid = 1'b0; opd_d = '1; opd_m = '0; mode = 2'b01;
        @(negedge clk);
        check("R8 hold", {out_valid, flags_nzcv, invalid}, {1'b0, held_f, held_i});
        @(negedge clk);
        check("R8 hold2", {out_valid, flags_nzcv, invalid}, {1'b0, held_f, held_i});
        // Directed full-width cases
        in_valid32 = 1'b1;
        d32 = 32'h3F80_0000; m32 = 32'h4000_0000; mode32 = 2'b00;
        @(negedge clk); check("R6 32b 1<2", {ov32, fl32, inv32}, 6'b110000);
        d32 = 32'hC000_0000; m32 = 32'hBF80_0000;
        @(negedge clk); check("R6 32b -2<-1", {ov32, fl32, inv32}, 6'b110000);
        d32 = 32'h8000_0000; m32 = 32'h0000_0000;
        @(negedge clk); check("R4 32b -0==+0", {ov32, fl32, inv32}, 6'b101100);
        d32 = 32'h7FC0_0000; m32 = 32'h3F80_0000;
        @(negedge clk); check("R3 32b qnan quiet", {ov32, fl32, inv32}, 6'b100110);
        mode32 = 2'b01;
        @(negedge clk); check("R3 32b qnan signalling", {ov32, fl32, inv32}, 6'b100111);
        d32 = 32'hBF80_0000; m32 = 32'h7FA0_0000; mode32 = 2'b10;
        @(negedge clk); check("R7 32b -1 vs zero", {ov32, fl32, inv32}, 6'b110000);
        in_valid32 = 1'b0;
        @(negedge clk); check("R8 32b valid drop", {ov32}, 6'b0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule